// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Dispatch

This block produces the next control-store address for a microcoded 8-bit processor. On every clock the control store returns the microword found at the current micro-PC. The sequencer looks at two bits of that word. It then either steps the micro-PC by one or loads it with a jump target. The target is either the address field carried inside the microword or the value held in the instruction register. The second case lets a fetched opcode branch straight into its own microroutine, with no separate mapping table.

The microword is also captured in a pipeline register. The control strobes it carries therefore stay steady for the whole cycle after the control store was read. The datapath, the memory and the loading of the control store at boot lie outside this block.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `uPc` to 0 and `mwOut` to 0 after that edge.
- R2: If bit 1 of `mcWord` is 0, the next `uPc` is the current `uPc` plus one. Address 511 wraps to 0.
- R3: If bit 1 is 1 and bit 0 is 0, the next `uPc` is taken from `mcWord` bits 10 down to 2. Bit 2 is the least significant bit of that field.
- R4: If bits 1 and 0 are both 1, the next `uPc` is `irValue` with a zero in the top bit. The field in bits 10:2 has no effect on it.
- R5: While bit 1 is 0, neither bit 0 nor `irValue` changes the next `uPc`. While bit 0 is 0, `irValue` has no effect.
- R6: Out of reset, `mwOut` equals all 26 bits of the `mcWord` that was presented at the previous rising edge.
- R7: Reset is synchronous. A reset raised in the middle of a run takes effect at the next edge and overrides any pending jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mcWord | input | 26 | Microword read from the control store at `uPc` |
| irValue | input | 8 | Instruction register contents, used as the dispatch target |
| uPc | output | 9 | Micro-PC, i.e. the control-store read address |
| mwOut | output | 26 | Registered microword for the datapath |

## Verification
The bench builds the block with its default widths: a 26-bit word, a 9-bit micro-PC and an 8-bit IR. At these sizes every address and every opcode can be visited. The bench does this with three sweeps:
- a run of 513 plain steps, which passes the wrap from 511 back to 0;
- a jump to each of the 512 embedded targets, each made with unrelated IR contents;
- a dispatch of each of the 256 opcodes, each made with a deliberately wrong address field.

A reset raised in the middle of a jump closes the run.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef struct packed {
    logic loadTarget;
    logic useIr;
  } seqStrobes_t;
endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int WORD_W    = 26,
  parameter int ADDR_W    = 9,
  parameter int SRC_BIT   = 0,
  parameter int LOAD_BIT  = 1,
  parameter int FIELD_LSB = 2
) (
  input  logic [WORD_W-1:0] mcWord,
  output seqStrobes_t       strobes,
  output logic [ADDR_W-1:0] jumpField
);
  localparam int FIELD_MSB = FIELD_LSB + ADDR_W - 1;

  always_comb begin
    strobes.loadTarget = mcWord[LOAD_BIT];
    strobes.useIr      = mcWord[SRC_BIT];
    jumpField          = mcWord[FIELD_MSB:FIELD_LSB];
  end
endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int WORD_W = 26,
  parameter int ADDR_W = 9,
  parameter int IR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] jumpField,
  input  logic [IR_W-1:0]   irValue,
  input  logic [WORD_W-1:0] mcWord,
  output logic [ADDR_W-1:0] uPc,
  output logic [WORD_W-1:0] mwOut
);
  logic [ADDR_W-1:0] irTarget;
  logic [ADDR_W-1:0] nextPc;

  generate
    if (ADDR_W > IR_W) begin : g_irPad
      assign irTarget = {{(ADDR_W-IR_W){1'b0}}, irValue};
    end else begin : g_irTrim
      assign irTarget = irValue[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    if (!strobes.loadTarget) nextPc = uPc + 1'b1;
    else if (strobes.useIr)  nextPc = irTarget;
    else                     nextPc = jumpField;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uPc   <= '0;
      mwOut <= '0;
    end else begin
      uPc   <= nextPc;
      mwOut <= mcWord;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (uPc == '0 && mwOut == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !mcWord[1] |=> uPc == ADDR_W'($past(uPc) + 1'b1));

  a_r3_embedded: assert property (@(posedge clk) disable iff (rst)
    (mcWord[1] && !mcWord[0]) |=> uPc == $past(mcWord[ADDR_W+1:2]));

  a_r4_dispatch: assert property (@(posedge clk) disable iff (rst)
    (mcWord[1] && mcWord[0]) |=> uPc == ADDR_W'($past(irValue)));

  a_r6_pipe: assert property (@(posedge clk) disable iff (rst)
    !rst |=> mwOut == $past(mcWord));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int WORD_W = 26,
  parameter int ADDR_W = 9,
  parameter int IR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mcWord,
  input  logic [IR_W-1:0]   irValue,
  output logic [ADDR_W-1:0] uPc,
  output logic [WORD_W-1:0] mwOut
);
  seqStrobes_t       strobes;
  logic [ADDR_W-1:0] jumpField;

  useq_ctrl #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .SRC_BIT(0), .LOAD_BIT(1), .FIELD_LSB(2)
  ) u_ctrl (
    .mcWord(mcWord), .strobes(strobes), .jumpField(jumpField)
  );

  useq_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IR_W(IR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .jumpField(jumpField),
    .irValue(irValue), .mcWord(mcWord), .uPc(uPc), .mwOut(mwOut)
  );
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int WORD_W = 26;
  localparam int ADDR_W = 9;
  localparam int IR_W   = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IR_W-1:0]   irValue = '0;
  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] mcWord;
  logic [ADDR_W-1:0] uPc;
  logic [WORD_W-1:0] mwOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign mcWord = store[uPc];

  useq_top dut (
    .clk(clk), .rst(rst), .mcWord(mcWord), .irValue(irValue),
    .uPc(uPc), .mwOut(mwOut)
  );

  task automatic check(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Places word at the current address, clocks once, checks outputs.
  task automatic stepCheck(string req, logic [WORD_W-1:0] word,
                           logic [IR_W-1:0] ir, logic [ADDR_W-1:0] expPc);
    store[uPc] = word;
    irValue = ir;
    @(posedge clk);
    @(negedge clk);
    check(req, WORD_W'(uPc), WORD_W'(expPc));
    check("R6", mwOut, word);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", WORD_W'(uPc), '0);
    check("R1", mwOut, '0);
    rst = 1'b0;

    // R2 / R5: plain steps through the whole space and across the wrap
    for (int s = 0; s < DEPTH + 1; s++) begin
      logic [WORD_W-1:0] w;
      w = WORD_W'($urandom);
      w[1] = 1'b0;
      w[0] = s[0];
      stepCheck("R2", w, IR_W'($urandom), ADDR_W'(uPc + 1));
    end

    // R3 / R5: every embedded target, IR contents unrelated
    for (int t = 0; t < DEPTH; t++) begin
      logic [WORD_W-1:0] w;
      w = WORD_W'($urandom);
      w[1:0] = 2'b10;
      w[ADDR_W+1:2] = ADDR_W'(t);
      stepCheck("R3", w, IR_W'(t ^ 8'hA5), ADDR_W'(t));
    end

    // R4: every opcode dispatched, address field set to a wrong value
    for (int i = 0; i < (1 << IR_W); i++) begin
      logic [WORD_W-1:0] w;
      w = WORD_W'($urandom);
      w[1:0] = 2'b11;
      w[ADDR_W+1:2] = ~ADDR_W'(i);
      stepCheck("R4", w, IR_W'(i), ADDR_W'(i));
    end

    // R7: reset raised while a jump is pending wins
    begin
      logic [WORD_W-1:0] w;
      w = '0;
      w[1:0] = 2'b10;
      w[ADDR_W+1:2] = ADDR_W'(300);
      store[uPc] = w;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R7", WORD_W'(uPc), '0);
      check("R7", mwOut, '0);
      rst = 1'b0;
      store[0] = '0;
      @(posedge clk);
      @(negedge clk);
      check("R7", WORD_W'(uPc), WORD_W'(1));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule